// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block is the control state machine that brings up to three supply rails up and down. It sees synchronized comparator flags: an undervoltage-OK flag per rail, two enable flags (above the rising threshold and below the falling threshold), an internal-supply-valid flag, and an output-good flag and an output-low flag per rail. From these flags it drives a gate enable and a discharge pulldown enable per rail, plus an active-low fault line. The analog ramp block that actually slews the gates reports tracking errors back on a single flag.

There are two power-up styles, picked by a select input. In sequence style the rails come on one at a time, lowest index first. Each rail has a delay before it, and the next delay starts only once the previous rail is good. In track style one delay runs, and then every rail is released together. Both styles share one power-down: the gates are released as a group so that the outputs ramp down together. On a fault the block drops every gate, turns on the pulldowns and pulls the fault line low. It then either retries by itself after a wait of sixteen fault periods, or it latches off until the enable is cycled. A rail marked as not present is left out of all control.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, every gate enable and every pulldown enable is 0 and fault_n is 1.
- R2: Power-up begins only when supply_ok, en_above_rise and every uv_ok bit are 1 and every present rail reports out_low. The first gate rises DELAY_CYC cycles after the cycle in which those conditions are first sampled.
- R3: With track_sel=0, gate bit k+1 rises only after gate bit k. A delay of DELAY_CYC cycles starts only after rail k reports out_good, so consecutive rises are more than DELAY_CYC cycles apart.
- R4: With track_sel=1, a single DELAY_CYC delay runs, and then all present gate bits rise in the same cycle.
- R5: If the rail (sequence) or all rails (track) being powered do not reach out_good within FAULT_CYC cycles, all gates go to 0, the pulldowns of present rails go to 1 and fault_n goes to 0.
- R6: With retry_sel=1, fault_n stays low for exactly 16*FAULT_CYC cycles. After that, power-up restarts only once every present rail reports out_low.
- R7: With retry_sel=0, a fault holds all gates off and fault_n low until en_below_fall is seen and then en_above_rise. After that, fault_n stays low for a further 16*FAULT_CYC cycles before a restart.
- R8: When en_below_fall is 1 while all rails are on, every gate drops in the same cycle with no pulldown and fault_n stays 1.
- R9: When en_below_fall is 1 during power-up, before all rails are on, gates drop and the pulldowns of present rails turn on with fault_n remaining 1.
- R10: A rail whose rail_present bit is 0 never has its gate or pulldown enabled and does not hold up power-up.
- R11: track_fault=1 during a track ramp or a ramp-down causes the fault response of R5. This takes priority over an enable drop in the same cycle.
- R12: If any present rail loses out_good while all rails are on, the fault response of R5 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Internal supply valid |
| en_above_rise | input | 1 | Enable above rising threshold |
| en_below_fall | input | 1 | Enable below falling threshold |
| uv_ok | input | NUM_RAILS | Per-rail input above undervoltage threshold |
| rail_present | input | NUM_RAILS | Rail is under control (0 = excluded) |
| out_good | input | NUM_RAILS | Output above 92.5% of its input |
| out_low | input | NUM_RAILS | Output below the power-low level |
| track_sel | input | 1 | 1 = track power-up, 0 = sequence power-up |
| retry_sel | input | 1 | 1 = autoretry, 0 = latch-off |
| track_fault | input | 1 | Tracking error from the ramp block |
| gate_en | output | NUM_RAILS | Per-rail gate drive enable |
| pulldown_en | output | NUM_RAILS | Per-rail discharge pulldown enable |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The hardest state to reach is a retry that finds an output still high when the retry wait ends. The pulldowns normally drain every rail long before the sixteen-fault-period wait is over. The bench's rail model therefore has a stuck-high control. It is set at the moment a tracking error is injected and held through the whole wait, so the restart is seen to stall, and it is then released so the restart can proceed. The latch-off path needs a full enable cycle in the middle of a fault, and an injected output sag reaches the on state's fault path.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SEQ,
        ST_RAMP,
        ST_ON,
        ST_RAMP_DN,
        ST_FAST_OFF,
        ST_FAULT_WAIT,
        ST_LATCHED,
        ST_UNLATCH
    } ctl_state_e;

    typedef logic [3:0] rail_idx_t;

    typedef struct packed {
        ctl_state_e state;
        rail_idx_t  idx;
    } ctl_reg_t;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_rails.sv
module pwr_seq_rails
    import pwr_seq_pkg::*;
#(
    parameter int N = 3
) (
    input  logic [N-1:0] present,
    input  logic [N-1:0] good,
    input  logic [N-1:0] low,
    input  rail_idx_t    idx,
    output logic         all_good,
    output logic         all_low,
    output logic         idx_good,
    output logic [N-1:0] upto_mask,
    output logic [N-1:0] before_mask
);
    logic [N-1:0] eff_good, eff_low, sel_good;

    for (genvar i = 0; i < N; i++) begin : g_rail
        assign eff_good[i]    = good[i] | ~present[i];
        assign eff_low[i]     = low[i]  | ~present[i];
        assign sel_good[i]    = eff_good[i] & (idx == rail_idx_t'(i));
        assign upto_mask[i]   = present[i] & (idx >= rail_idx_t'(i));
        assign before_mask[i] = present[i] & (idx >  rail_idx_t'(i));
    end

    assign all_good = &eff_good;
    assign all_low  = &eff_low;
    assign idx_good = |sel_good;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NUM_RAILS = 3,
    parameter int DELAY_CYC = 200,
    parameter int FAULT_CYC = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 supply_ok,
    input  logic                 en_above_rise,
    input  logic                 en_below_fall,
    input  logic [NUM_RAILS-1:0] uv_ok,
    input  logic [NUM_RAILS-1:0] rail_present,
    input  logic [NUM_RAILS-1:0] out_good,
    input  logic [NUM_RAILS-1:0] out_low,
    input  logic                 track_sel,
    input  logic                 retry_sel,
    input  logic                 track_fault,
    output logic [NUM_RAILS-1:0] gate_en,
    output logic [NUM_RAILS-1:0] pulldown_en,
    output logic                 fault_n
);
    localparam int RETRY_CYC = 16 * FAULT_CYC;
    localparam int CW        = $clog2(RETRY_CYC + 1);
    localparam logic [CW-1:0] DLY_LD = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] FLT_LD = CW'(FAULT_CYC - 1);
    localparam logic [CW-1:0] RTY_LD = CW'(RETRY_CYC - 1);
    localparam rail_idx_t LAST_IDX = rail_idx_t'(NUM_RAILS - 1);

    ctl_reg_t st_d, st_q;
    logic ready, go_fault, expired, load;
    logic [CW-1:0] load_val;
    logic all_good, all_low, idx_good;
    logic [NUM_RAILS-1:0] upto_mask, before_mask;

    assign ready = supply_ok & en_above_rise & (&uv_ok);

    pwr_seq_rails #(.N(NUM_RAILS)) rails_i (
        .present     (rail_present),
        .good        (out_good),
        .low         (out_low),
        .idx         (st_q.idx),
        .all_good    (all_good),
        .all_low     (all_low),
        .idx_good    (idx_good),
        .upto_mask   (upto_mask),
        .before_mask (before_mask)
    );

    always_comb begin
        st_d     = st_q;
        go_fault = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (ready && all_low) begin
                    st_d.state = ST_DELAY;
                    st_d.idx   = '0;
                end
            end
            ST_DELAY: begin
                if (en_below_fall)
                    st_d.state = (before_mask != '0) ? ST_FAST_OFF : ST_IDLE;
                else if (expired && ready)
                    st_d.state = track_sel ? ST_RAMP : ST_SEQ;
            end
            ST_SEQ: begin
                if (expired && !idx_good)
                    go_fault = 1'b1;
                else if (en_below_fall)
                    st_d.state = ST_FAST_OFF;
                else if (idx_good) begin
                    if (st_q.idx == LAST_IDX) begin
                        st_d.state = ST_ON;
                    end else begin
                        st_d.state = ST_DELAY;
                        st_d.idx   = st_q.idx + rail_idx_t'(1);
                    end
                end
            end
            ST_RAMP: begin
                if (track_fault || (expired && !all_good))
                    go_fault = 1'b1;
                else if (en_below_fall)
                    st_d.state = ST_FAST_OFF;
                else if (all_good)
                    st_d.state = ST_ON;
            end
            ST_ON: begin
                if (!all_good)
                    go_fault = 1'b1;
                else if (en_below_fall)
                    st_d.state = ST_RAMP_DN;
            end
            ST_RAMP_DN: begin
                if (track_fault)
                    go_fault = 1'b1;
                else if (all_low)
                    st_d.state = ST_IDLE;
            end
            ST_FAST_OFF: begin
                if (all_low) st_d.state = ST_IDLE;
            end
            ST_FAULT_WAIT: begin
                if (expired) st_d.state = ST_IDLE;
            end
            ST_LATCHED: begin
                if (en_below_fall) st_d.state = ST_UNLATCH;
            end
            ST_UNLATCH: begin
                if (en_above_rise) st_d.state = ST_FAULT_WAIT;
            end
            default: st_d.state = ST_IDLE;
        endcase
        if (go_fault)
            st_d.state = retry_sel ? ST_FAULT_WAIT : ST_LATCHED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, idx: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        load = (st_d != st_q);
        case (st_d.state)
            ST_DELAY:          load_val = DLY_LD;
            ST_SEQ, ST_RAMP:   load_val = FLT_LD;
            ST_FAULT_WAIT:     load_val = RTY_LD;
            default:           load_val = '0;
        endcase
    end

    pwr_seq_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    always_comb begin
        gate_en     = '0;
        pulldown_en = '0;
        fault_n     = 1'b1;
        case (st_q.state)
            ST_DELAY:       gate_en = before_mask;
            ST_SEQ:         gate_en = upto_mask;
            ST_RAMP, ST_ON: gate_en = rail_present;
            ST_FAST_OFF:    pulldown_en = rail_present;
            ST_FAULT_WAIT, ST_LATCHED, ST_UNLATCH: begin
                pulldown_en = rail_present;
                fault_n     = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         supply_ok,
    input logic         en_above_rise,
    input logic         en_below_fall,
    input logic [N-1:0] uv_ok,
    input logic [N-1:0] rail_present,
    input logic [N-1:0] gate_en,
    input logic [N-1:0] pulldown_en,
    input logic         fault_n
);
    // R5
    gate_off_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_en == '0));

    // R9
    pd_gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulldown_en != '0) |-> (gate_en == '0));

    // R8
    en_drop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_below_fall && gate_en != '0) |=> (gate_en == '0));

    // R2
    gate_rise_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_en & ~$past(gate_en)) != '0) |-> $past(supply_ok && en_above_rise && (&uv_ok)));

    for (genvar i = 1; i < N; i++) begin : g_order
        // R3
        seq_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en[i] |-> (gate_en[i-1] || !rail_present[i-1]));
    end
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.N(NUM_RAILS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .en_above_rise (en_above_rise),
    .en_below_fall (en_below_fall),
    .uv_ok         (uv_ok),
    .rail_present  (rail_present),
    .gate_en       (gate_en),
    .pulldown_en   (pulldown_en),
    .fault_n       (fault_n)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
    localparam int NR  = 3;
    localparam int DLY = 8;
    localparam int FLT = 30;
    localparam int RTY = 16 * FLT;

    logic clk = 1'b0, rst_n = 1'b0;
    logic supply_ok = 1'b1, en_hi = 1'b0, en_lo = 1'b1, track_sel = 1'b0;
    logic retry_sel = 1'b1, track_fault = 1'b0;
    logic [NR-1:0] uv_ok = '1, present = '1, good, low;
    logic [NR-1:0] gate_en, pd_en;
    logic fault_n;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    int level [NR];
    int rate [NR];
    bit stuck [NR];
    bit sag [NR];

    always #4 clk = ~clk;

    pwr_seq_ctrl #(.NUM_RAILS(NR), .DELAY_CYC(DLY), .FAULT_CYC(FLT)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .en_above_rise(en_hi), .en_below_fall(en_lo), .uv_ok(uv_ok),
        .rail_present(present), .out_good(good), .out_low(low),
        .track_sel(track_sel), .retry_sel(retry_sel), .track_fault(track_fault),
        .gate_en(gate_en), .pulldown_en(pd_en), .fault_n(fault_n)
    );

    // rail plant
    initial begin
        for (int i = 0; i < NR; i++) begin level[i] = 0; rate[i] = 4; stuck[i] = 0; sag[i] = 0; end
        good = '0; low = '1;
    end
    always @(negedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (!present[i])      level[i] = 0;
            else if (stuck[i])    level[i] = 100;
            else if (sag[i])      level[i] = 50;
            else if (gate_en[i])  level[i] = (level[i] + rate[i] > 100) ? 100 : level[i] + rate[i];
            else if (pd_en[i])    level[i] = (level[i] < 20) ? 0 : level[i] - 20;
            else                  level[i] = (level[i] < 3) ? 0 : level[i] - 3;
            good[i] = (level[i] >= 93);
            low[i]  = (level[i] <= 5);
        end
    end

    // behavioural reference: phases 0 idle,1 wait-delay,2 one-rail-up,3 all-up,
    // 4 on,5 down,6 quick-off,7 retry-wait,8 latched,9 latched-en-low
    int ph = 0, ri = 0, tmr = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; ri = 0; tmr = 0;
        end else begin
            int np, ni;
            bit rdy, allg, alll, curg, flt, anyon;
            rdy = supply_ok && en_hi && (uv_ok == '1);
            allg = 1; alll = 1; anyon = 0;
            for (int i = 0; i < NR; i++) begin
                if (present[i] && !good[i]) allg = 0;
                if (present[i] && !low[i]) alll = 0;
                if (present[i] && i < ri) anyon = 1;
            end
            curg = !present[ri] || good[ri];
            np = ph; ni = ri; flt = 0;
            case (ph)
                0: if (rdy && alll) begin np = 1; ni = 0; end
                1: if (en_lo) np = anyon ? 6 : 0;
                   else if (tmr == 0 && rdy) np = track_sel ? 3 : 2;
                2: if (tmr == 0 && !curg) flt = 1;
                   else if (en_lo) np = 6;
                   else if (curg) begin
                       if (ri == NR - 1) np = 4; else begin np = 1; ni = ri + 1; end
                   end
                3: if (track_fault || (tmr == 0 && !allg)) flt = 1;
                   else if (en_lo) np = 6;
                   else if (allg) np = 4;
                4: if (!allg) flt = 1; else if (en_lo) np = 5;
                5: if (track_fault) flt = 1; else if (alll) np = 0;
                6: if (alll) np = 0;
                7: if (tmr == 0) np = 0;
                8: if (en_lo) np = 9;
                9: if (en_hi) np = 7;
                default: np = 0;
            endcase
            if (flt) np = retry_sel ? 7 : 8;
            if (np != ph || ni != ri)
                tmr = (np == 1) ? DLY - 1 : (np == 2 || np == 3) ? FLT - 1 : (np == 7) ? RTY - 1 : 0;
            else if (tmr > 0)
                tmr = tmr - 1;
            ph = np; ri = ni;
        end
    end

    function automatic logic [NR-1:0] exp_gate();
        logic [NR-1:0] g = '0;
        for (int i = 0; i < NR; i++)
            g[i] = present[i] && ((ph == 2 && i <= ri) || (ph == 1 && i < ri) || ph == 3 || ph == 4);
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [NR-1:0] ep;
            ep = (ph >= 6) ? present : '0;
            check(gate_en == exp_gate(), cur_req, "model gate_en", gate_en, exp_gate());
            check(pd_en == ep, cur_req, "model pulldown_en", pd_en, ep);
            check(fault_n == !(ph >= 7), cur_req, "model fault_n", fault_n, !(ph >= 7));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic en_on();  en_hi = 1'b1; en_lo = 1'b0; endtask
    task automatic en_off(); en_hi = 1'b0; en_lo = 1'b1; endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, cur_req, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int t [NR];
        int c;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1
        check(gate_en == '0 && pd_en == '0 && fault_n, "R1", "reset outputs", {gate_en, pd_en}, 0);

        // R2: one undervoltage flag low blocks start
        cur_req = "R2";
        uv_ok = 3'b011; en_on();
        cyc(40);
        check(gate_en == '0, "R2", "no start with uv low", gate_en, 0);
        uv_ok = '1;

        // R3: sequence order
        cur_req = "R3";
        for (int i = 0; i < NR; i++) t[i] = -1;
        for (int k = 1; k <= 300; k++) begin
            cyc(1);
            for (int i = 0; i < NR; i++) if (gate_en[i] && t[i] < 0) t[i] = k;
        end
        check(t[0] == DLY + 1, "R2", "first gate time after start", t[0], DLY + 1);
        check(t[1] > t[0] + DLY, "R3", "rail2 after rail1 plus delay", t[1], t[0] + DLY + 1);
        check(t[2] > t[1] + DLY, "R3", "rail3 after rail2 plus delay", t[2], t[1] + DLY + 1);
        check(gate_en == 3'b111, "R3", "all rails on", gate_en, 7);

        // R8: orderly power-down
        cur_req = "R8";
        en_off();
        cyc(1);
        check(gate_en == '0 && pd_en == '0 && fault_n, "R8", "group release, no pulldown", {gate_en, pd_en}, 0);
        cyc(60);

        // R4: tracked power-up
        cur_req = "R4";
        track_sel = 1'b1;
        for (int i = 0; i < NR; i++) t[i] = -1;
        en_on();
        for (int k = 1; k <= 100; k++) begin
            cyc(1);
            for (int i = 0; i < NR; i++) if (gate_en[i] && t[i] < 0) t[i] = k;
        end
        check(t[0] == DLY + 1, "R4", "tracked start time", t[0], DLY + 1);
        check(t[1] == t[0] && t[2] == t[0], "R4", "all gates same cycle", t[2], t[0]);
        en_off(); cyc(60);

        // R5 / R6: timeout in sequence, autoretry
        cur_req = "R5";
        track_sel = 1'b0; rate[1] = 0; en_on();
        c = 0;
        while (fault_n && c < 400) begin cyc(1); c++; end
        check(!fault_n && gate_en == '0 && pd_en == 3'b111, "R5", "timeout fault response", {gate_en, pd_en}, 7);
        rate[1] = 4;
        cur_req = "R6";
        c = 0;
        while (!fault_n && c < 2000) begin c++; cyc(1); end
        check(c == RTY, "R6", "retry wait cycles", c, RTY);
        cyc(300);
        check(gate_en == 3'b111, "R6", "restart after retry", gate_en, 7);
        en_off(); cyc(60);

        // R11 + R6 stuck output: tracking error beats enable drop
        cur_req = "R11";
        track_sel = 1'b1; en_on();
        c = 0;
        while (gate_en == '0 && c < 100) begin cyc(1); c++; end
        track_fault = 1'b1; en_off(); stuck[0] = 1;
        cyc(1);
        track_fault = 1'b0;
        check(!fault_n, "R11", "tracking error gives fault", fault_n, 0);
        en_on();
        cur_req = "R6";
        cyc(RTY + 40);
        check(gate_en == '0 && fault_n, "R6", "no restart while output high", gate_en, 0);
        stuck[0] = 0;
        cyc(150);
        check(gate_en == 3'b111, "R6", "restart once outputs low", gate_en, 7);
        en_off(); cyc(60);

        // R9: enable drop during power-up
        cur_req = "R9";
        track_sel = 1'b0; en_on();
        c = 0;
        while (!gate_en[0] && c < 100) begin cyc(1); c++; end
        en_off();
        cyc(1);
        check(gate_en == '0 && pd_en == 3'b111 && fault_n, "R9", "fast shutdown", pd_en, 7);
        cyc(40);

        // R7: latch-off
        cur_req = "R7";
        retry_sel = 1'b0; rate[2] = 0; en_on();
        cyc(RTY + 200);
        check(!fault_n && gate_en == '0, "R7", "latched with enable high", fault_n, 0);
        en_off(); cyc(5);
        check(!fault_n, "R7", "still latched with enable low", fault_n, 0);
        rate[2] = 4; en_on();
        c = 0;
        cyc(1);
        while (!fault_n && c < 2000) begin c++; cyc(1); end
        check(c == RTY, "R7", "retry wait after enable cycle", c, RTY);
        cyc(300);
        check(gate_en == 3'b111, "R7", "restart after latch release", gate_en, 7);
        en_off(); cyc(80);
        retry_sel = 1'b1;

        // R10: excluded rail
        cur_req = "R10";
        present = 3'b011; en_on();
        cyc(250);
        check(gate_en == 3'b011 && fault_n, "R10", "excluded rail left off", gate_en, 3);
        en_off(); cyc(60);
        check(pd_en[2] == 1'b0, "R10", "excluded rail no pulldown", pd_en, 0);
        present = 3'b111;

        // R12: rail sags while on
        cur_req = "R12";
        en_on(); cyc(300);
        sag[1] = 1;
        cyc(3);
        check(!fault_n && gate_en == '0, "R12", "sag while on gives fault", fault_n, 0);
        sag[1] = 0; en_off();
        cyc(RTY + 40);
        finish_run();
    end
endmodule